// File: doc/BRIEF.md
# UART Data Register Port with Character FIFOs

This block is the bus-facing data front end of a 16550-class serial port. A single register slot (offset 0) is shared three ways. A write to it queues a character for transmission. A read from it takes the oldest received character. While the divisor-access bit in the line-control register is set, the same slot instead reaches the low byte of the baud divisor, which is exported as `div_lo`.

Behind the slot sit two character queues, one for transmit and one for receive, each `DEPTH` entries deep. A bit in the FIFO-control register enables them. With the queues disabled, each direction holds exactly one character. The line-status register reports data-ready, overrun and transmit-holding-empty. The serial shifters are outside this block. They are represented by a receive strobe (`rx_valid`/`rx_char`) and a transmit handshake (`tx_valid`/`tx_char`/`tx_take`).

Register slots: 0 data or divisor-low, 2 FIFO control (write only), 3 line control, 5 line status (read only). Every other slot reads as zero. Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd`.

Top module: `uart_data_port`

## Requirements
- R1: With line-control bit 7 clear, a write to slot 0 queues `bus_wdata[7:0]` for transmit. A read of slot 0 returns and removes the oldest received character, in arrival order.
- R2: With line-control bit 7 set, slot 0 reads and writes the divisor low byte (`div_lo`), and neither queue nor the line status is changed by that access.
- R3: Only bits 7:0 of any register carry data. Bits 31:8 of `bus_rdata` are always zero and bits 31:8 of a write are ignored. After reset the divisor byte, line control and read data are 0 and line status is 0x20.
- R4: When FIFO-control bit 0 is 1, each queue holds up to 16 characters (`DEPTH`).
- R5: Line-status bit 0 (data ready) is 1 exactly while the receive side holds at least one character.
- R6: With queues enabled, a character arriving while the receive queue is full is dropped, the stored characters are kept, and line-status bit 1 (overrun) is set.
- R7: With queues disabled, each direction holds one character. A second received character arriving before the first is read replaces it and sets overrun. A second transmit write while one is held is discarded.
- R8: A read of line status returns the current overrun bit and then clears it, unless a new drop occurs in the same cycle.
- R9: Line-status bit 5 is 1 while the transmit side is empty and goes to 0 after an accepted write. From empty, 16 writes are accepted in FIFO mode.
- R10: A transmit write while the transmit queue is full is discarded, and the queued characters and their order are unchanged.
- R11: Writing FIFO-control bit 1 empties the receive queue and bit 2 empties the transmit queue. These bits are not stored. Changing bit 0 empties both queues.
- R12: `tx_valid` is 1 while a transmit character is held, `tx_char` shows the oldest one, and `tx_take` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register slot select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_char | input | 8 | Received character |
| tx_valid | output | 1 | A transmit character is waiting |
| tx_char | output | 8 | Oldest transmit character |
| tx_take | input | 1 | The transmitter consumes `tx_char` |
| div_lo | output | 8 | Divisor low byte |

## Verification
A wrong queue pointer or level shows up as characters coming out of slot 0 or `tx_char` in the wrong order, repeated or missing. The first read after the fault exposes it, so the bench drains every queue it fills and compares each character. A stuck or misplaced overrun or empty flag shows in the next line-status read, one cycle after the strobe. A divisor write leaking into the data path shows as a changed line status or an unexpected `tx_valid` straight after the access.

// File: rtl/uart_dp_pkg.sv
package uart_dp_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] SLOT_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] SLOT_FCTL = 3'd2;
  localparam logic [ADDR_W-1:0] SLOT_LCTL = 3'd3;
  localparam logic [ADDR_W-1:0] SLOT_LSTA = 3'd5;
  localparam int FCTL_EN    = 0;
  localparam int FCTL_RXCLR = 1;
  localparam int FCTL_TXCLR = 2;
  localparam int LCTL_DIVSEL = 7;
  localparam int LSTA_DR   = 0;
  localparam int LSTA_OVR  = 1;
  localparam int LSTA_THRE = 5;
endpackage

// File: rtl/uart_dp_fifo.sv
module uart_dp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          multi,
  input  logic          ovw,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wa;
  logic [CW-1:0] cap;
  logic          do_pop, do_push, do_ovw, we;

  assign cap     = multi ? CW'(DEPTH) : CW'(1);
  assign empty   = (level == '0);
  assign full    = (level >= cap);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && full && !do_pop;
  assign do_ovw  = drop && ovw;
  assign we      = (do_push || do_ovw) && !flush;
  // overwrite mode replaces the single held entry at the read pointer
  assign wa      = do_push ? wr_ptr : rd_ptr;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      level <= level + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/uart_dp_status.sv
module uart_dp_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_held,
  input  logic       tx_empty,
  input  logic       rx_drop,
  input  logic       sta_read,
  output logic [7:0] sta
);
  import uart_dp_pkg::*;
  logic ovr;

  always_ff @(posedge clk) begin
    if (rst)           ovr <= 1'b0;
    else if (rx_drop)  ovr <= 1'b1;
    else if (sta_read) ovr <= 1'b0;
  end

  always_comb begin
    sta            = '0;
    sta[LSTA_DR]   = rx_held;
    sta[LSTA_OVR]  = ovr;
    sta[LSTA_THRE] = tx_empty;
  end
endmodule

// File: rtl/uart_data_port.sv
module uart_data_port #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int BUS_W = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_char,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_char,
  input  logic             tx_take,
  output logic [DW-1:0]    div_lo
);
  import uart_dp_pkg::*;

  logic [DW-1:0] lctl, rx_head, rd_mux, wbyte;
  logic [7:0]    lsta;
  logic          fifo_en, divsel;
  logic          wr_data, wr_div, wr_fctl, wr_lctl, rd_data, rd_lsta;
  logic          rx_flush, tx_flush, en_change;
  logic          rx_pop, tx_push;
  logic          rx_empty, rx_full, rx_drop;
  logic          tx_empty, tx_full, tx_drop;
  logic [CW-1:0] rx_level, tx_level;
  logic          unused_bits;

  assign wbyte       = bus_wdata[DW-1:0];
  assign unused_bits = ^{bus_wdata[BUS_W-1:DW], tx_drop};
  assign divsel      = lctl[LCTL_DIVSEL];
  assign wr_data     = bus_wr && bus_addr == SLOT_DATA && !divsel;
  assign wr_div      = bus_wr && bus_addr == SLOT_DATA &&  divsel;
  assign wr_fctl     = bus_wr && bus_addr == SLOT_FCTL;
  assign wr_lctl     = bus_wr && bus_addr == SLOT_LCTL;
  assign rd_data     = bus_rd && bus_addr == SLOT_DATA && !divsel;
  assign rd_lsta     = bus_rd && bus_addr == SLOT_LSTA;
  assign en_change   = wr_fctl && (wbyte[FCTL_EN] != fifo_en);
  assign rx_flush    = wr_fctl && (wbyte[FCTL_RXCLR] || en_change);
  assign tx_flush    = wr_fctl && (wbyte[FCTL_TXCLR] || en_change);
  assign rx_pop      = rd_data;
  assign tx_push     = wr_data;
  assign tx_valid    = !tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      lctl    <= '0;
      div_lo  <= '0;
      fifo_en <= 1'b0;
    end else begin
      if (wr_lctl) lctl    <= wbyte;
      if (wr_div)  div_lo  <= wbyte;
      if (wr_fctl) fifo_en <= wbyte[FCTL_EN];
    end
  end

  uart_dp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .multi(fifo_en), .ovw(!fifo_en),
    .push(rx_valid), .din(rx_char), .pop(rx_pop), .dout(rx_head),
    .level(rx_level), .empty(rx_empty), .full(rx_full), .drop(rx_drop)
  );

  uart_dp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .multi(fifo_en), .ovw(1'b0),
    .push(tx_push), .din(wbyte), .pop(tx_take), .dout(tx_char),
    .level(tx_level), .empty(tx_empty), .full(tx_full), .drop(tx_drop)
  );

  uart_dp_status u_sta (
    .clk(clk), .rst(rst), .rx_held(!rx_empty), .tx_empty(tx_empty),
    .rx_drop(rx_drop), .sta_read(rd_lsta), .sta(lsta)
  );

  always_comb begin
    case (bus_addr)
      SLOT_DATA: rd_mux = divsel ? div_lo : rx_head;
      SLOT_LCTL: rd_mux = lctl;
      SLOT_LSTA: rd_mux = lsta[DW-1:0];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{(BUS_W-DW){1'b0}}, rd_mux};
  end
endmodule

// File: rtl/uart_data_port_chk.sv
module uart_data_port_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          rx_valid,
  input logic          tx_take,
  input logic          wr_div,
  input logic          rd_lsta,
  input logic          rx_full,
  input logic          rx_pop,
  input logic          tx_full,
  input logic          tx_push,
  input logic          rx_flush,
  input logic          tx_flush,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] tx_level,
  input logic [7:0]    lsta,
  input logic [7:0]    div_lo
);
  p_level_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_level <= CW'(DEPTH)) && (tx_level <= CW'(DEPTH)));

  p_dr_on_arrival_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_flush |=> lsta[0]);

  p_ovr_on_drop_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_full && !rx_pop |=> lsta[1]);

  p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
    rd_lsta && !(rx_valid && rx_full && !rx_pop) |=> !lsta[1]);

  p_thre_low_r9: assert property (@(posedge clk) disable iff (rst)
    tx_push && !tx_full && !tx_flush |=> !lsta[5]);

  p_full_keep_r10: assert property (@(posedge clk) disable iff (rst)
    tx_push && tx_full && !tx_take && !tx_flush |=> $stable(tx_level));

  p_div_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && wr_div) |=> $stable(div_lo));
endmodule

bind uart_data_port uart_data_port_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .rx_valid(rx_valid), .tx_take(tx_take),
  .wr_div(wr_div), .rd_lsta(rd_lsta), .rx_full(rx_full), .rx_pop(rx_pop),
  .tx_full(tx_full), .tx_push(tx_push), .rx_flush(rx_flush), .tx_flush(tx_flush),
  .rx_level(rx_level), .tx_level(tx_level), .lsta(lsta), .div_lo(div_lo)
);

// File: tb/sim_uart_data_port.sv
`timescale 1ns/1ps
module sim_uart_data_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        tx_valid;
  logic [7:0]  tx_char;
  logic        tx_take = 1'b0;
  logic [7:0]  div_lo;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  uart_data_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_char(rx_char), .tx_valid(tx_valid), .tx_char(tx_char),
    .tx_take(tx_take), .div_lo(div_lo)
  );

  // op: 0 write, 1 read-and-compare, 2 receive char, 3 take tx char and compare
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 3'd3, 8'h80, 8'h00},  // R2 select divisor
    {2'd0, 3'd0, 8'h5A, 8'h00},  // R2
    {2'd1, 3'd0, 8'h00, 8'h5A},  // R2 readback
    {2'd1, 3'd5, 8'h00, 8'h20},  // R2 status untouched
    {2'd0, 3'd3, 8'h03, 8'h00},
    {2'd1, 3'd3, 8'h00, 8'h03},  // R3 line control readback
    {2'd0, 3'd2, 8'h01, 8'h00},  // R4 enable queues
    {2'd2, 3'd0, 8'h11, 8'h00},
    {2'd2, 3'd0, 8'h22, 8'h00},
    {2'd1, 3'd5, 8'h00, 8'h21},  // R5 data ready
    {2'd1, 3'd0, 8'h00, 8'h11},  // R1 order
    {2'd1, 3'd0, 8'h00, 8'h22},  // R1
    {2'd1, 3'd5, 8'h00, 8'h20},  // R5 drained
    {2'd0, 3'd0, 8'h33, 8'h00},  // R1 transmit write
    {2'd1, 3'd5, 8'h00, 8'h00},  // R9 THRE low
    {2'd3, 3'd0, 8'h00, 8'h33},  // R12 take
    {2'd1, 3'd5, 8'h00, 8'h20}   // R9 THRE high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic rx(input logic [7:0] c);
    @(negedge clk); rx_char = c; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic take_chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {23'd0, tx_valid, tx_char}, {23'd0, 1'b1, exp});
    tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    check("R3 rdata", bus_rdata, 32'h0);
    check("R12 tx_valid", {31'd0, tx_valid}, 32'h0);
    check("R3 div_lo", {24'd0, div_lo}, 32'h0);
    rd_chk("R3 status", 3'd5, 32'h20);
    rd_chk("R3 lctl", 3'd3, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [2:0] a; logic [7:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        2'd0: wr(a, {24'd0, d});
        2'd1: rd_chk($sformatf("vector %0d (R1/R2/R5/R9)", i), a, {24'd0, e});
        2'd2: rx(d);
        default: take_chk($sformatf("vector %0d R12", i), e);
      endcase
    end

    // R4, R6, R8: fill receive queue, overflow by one
    for (int i = 0; i < 17; i++) rx(8'hA0 + 8'(i));
    rd_chk("R6 overrun set", 3'd5, 32'h23);
    rd_chk("R8 overrun cleared", 3'd5, 32'h21);
    for (int i = 0; i < 16; i++) rd_chk("R4/R6 kept data", 3'd0, 32'hA0 + i);
    rd_chk("R5 empty", 3'd5, 32'h20);

    // R9, R10: fill transmit queue, one extra write
    for (int i = 0; i < 17; i++) wr(3'd0, 32'hFFFF_FFB0 + i);
    rd_chk("R9 THRE low", 3'd5, 32'h00);
    for (int i = 0; i < 16; i++) take_chk("R10 tx order", 8'hB0 + 8'(i));
    check("R10 extra discarded", {31'd0, tx_valid}, 32'h0);
    rd_chk("R9 THRE back", 3'd5, 32'h20);

    // R11 flushes
    rx(8'h61); rx(8'h62); wr(3'd0, 32'h71); wr(3'd0, 32'h72);
    wr(3'd2, 32'h07);
    rd_chk("R11 both flushed", 3'd5, 32'h20);
    check("R11 tx flushed", {31'd0, tx_valid}, 32'h0);
    rx(8'h63);
    wr(3'd2, 32'h01);
    rd_chk("R11 bits self-clear", 3'd5, 32'h21);
    rd_chk("R11 data survives", 3'd0, 32'h63);
    rx(8'h64);
    wr(3'd2, 32'h00);
    rd_chk("R11 mode change flush", 3'd5, 32'h20);

    // R7 single holding registers
    rx(8'h41); rx(8'h42);
    rd_chk("R7 overrun", 3'd5, 32'h23);
    rd_chk("R7 newest kept", 3'd0, 32'h42);
    rd_chk("R7 empty", 3'd5, 32'h20);
    wr(3'd0, 32'h51); wr(3'd0, 32'h52);
    take_chk("R7 tx first kept", 8'h51);
    check("R7 tx second dropped", {31'd0, tx_valid}, 32'h0);

    // R3 upper bits ignored
    wr(3'd3, 32'h80);
    wr(3'd0, 32'hFFFF_FF12);
    rd_chk("R3 upper zero", 3'd0, 32'h12);
    check("R2 div_lo", {24'd0, div_lo}, 32'h12);
    wr(3'd3, 32'h00);
    rd_chk("R2 queues untouched", 3'd5, 32'h20);
    check("R2 no tx", {31'd0, tx_valid}, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule